// File: doc/BRIEF.md
# Video Timing Reference Decoder

This block sits on the byte stream of a parallel digital video input. One byte arrives per pixel clock, qualified by a valid input. The stream has no separate sync pins. Line and field timing is carried inside the data as four-byte timing codes. Each code is three fixed bytes (0xFF, 0x00, 0x00) followed by a status byte. The status byte says whether the code opens or closes active video, which field is current, and whether the stream is in vertical blanking.

The decoder finds these codes and checks the protection bits of the status byte. From an accepted code it produces one-cycle start and end strobes and updates held field and blanking levels. It also keeps an active-video flag and marks each pixel byte inside an active line with a data-valid strobe. A status byte that fails its check raises an error pulse and changes nothing else.

When the parameter `BYTE_W` is above 8, only the upper eight bits of each byte take part in code matching and decoding, so the extra low-order bits of a wider bus are ignored.

Top module: `video_sync_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge, and the preamble match and active state are cleared.
- R2: A status byte is accepted only as the next valid byte after the valid bytes 0xFF, 0x00, 0x00 in that order. Cycles with `inValid` low neither advance nor break the match, and a preamble with any other byte in it gives no strobe.
- R3: A byte that breaks the preamble restarts matching. A 0xFF seen while the match is partway through counts as a new first preamble byte.
- R4: The status byte layout is: bit 7 must be 1, bit 6 is F, bit 5 is V, bit 4 is H, and bits 3..0 are P3..P0. An accepted status byte with H=0 pulses `savStrobe`, and one with H=1 pulses `eavStrobe`. The pulse lasts one cycle and appears right after the edge that samples the status byte.
- R5: On an accepted status byte, `fieldOut` takes F and `vblankOut` takes V, after the same edge. Both hold their values until the next accepted code.
- R6: The expected protection bits are P3 = V^H, P2 = F^H, P1 = F^V and P0 = F^V^H. If bits 3..0 differ from these, or bit 7 is 0, `protErr` pulses for one cycle. On that byte the SAV and EAV strobes stay low, and F, V and the active flag are left unchanged.
- R7: `activeVideo` goes to 1 on an accepted start code with V=0. It goes to 0 on an accepted end code, or on an accepted start code with V=1.
- R8: A valid byte sampled while `activeVideo` is 1 raises `pixelValid`, with the byte on `pixelData`, for the cycle after its edge. This does not happen if the byte is a code byte. Code bytes are: any 0xFF; a 0x00 that follows an unconsumed 0xFF, or that follows such an 0xFF, 0x00 pair; and a status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies `inByte` in this cycle |
| inByte | input | BYTE_W | Video stream byte |
| savStrobe | output | 1 | One-cycle pulse on an accepted start-of-active-video code |
| eavStrobe | output | 1 | One-cycle pulse on an accepted end-of-active-video code |
| fieldOut | output | 1 | Held field bit F |
| vblankOut | output | 1 | Held vertical-blanking bit V |
| activeVideo | output | 1 | High between an accepted start code (V=0) and its end code |
| pixelValid | output | 1 | One-cycle pulse for a pixel byte inside an active line |
| pixelData | output | BYTE_W | Pixel byte that goes with `pixelValid` |
| protErr | output | 1 | One-cycle pulse on a status byte that fails its check |

## Verification
A wrong preamble state shows up at the ports within one status byte. Either a real code's strobe is missing, or an ordinary byte turns into a strobe or a protection error. Either way, `pixelValid` flags code bytes as pixels, or the reverse, in the very next cycle. A wrong held F, V or active level stays wrong until the next accepted code. This shows up as a level mismatch on every following cycle, and also as pixels counted in blanking or lost in an active line. Comparing every output after every byte against a model built from the byte history therefore catches such faults within a few cycles of the fault.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  // Progress through the three fixed preamble bytes
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_FF   = 2'd1,
    M_FF00 = 2'd2,
    M_PRE  = 2'd3
  } matchState_t;

  // Strobes handed from control to datapath for the current byte
  typedef struct packed {
    logic statusWord;  // current valid byte is a status byte
    logic pixelByte;   // current valid byte is not part of a code
  } ctrlStrobe_t;

  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] PRE_FIRST = 8'hFF;
  localparam logic [CODE_W-1:0] PRE_ZERO  = 8'h00;

endpackage

// File: rtl/vsd_ctrl.sv
module vsd_ctrl
  import vsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [CODE_W-1:0] codeByte,
  output ctrlStrobe_t       strb
);

  matchState_t state, stateNext;
  logic isFirst, isZero, partOfCode;

  assign isFirst = (codeByte == PRE_FIRST);
  assign isZero  = (codeByte == PRE_ZERO);

  always_comb begin
    stateNext = state;
    if (byteValid) begin
      unique case (state)
        M_IDLE:  stateNext = isFirst ? M_FF : M_IDLE;
        M_FF:    stateNext = isZero ? M_FF00 : (isFirst ? M_FF : M_IDLE);
        M_FF00:  stateNext = isZero ? M_PRE  : (isFirst ? M_FF : M_IDLE);
        M_PRE:   stateNext = M_IDLE;  // status byte consumed
        default: stateNext = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= M_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    partOfCode = (state == M_PRE) || isFirst ||
                 (isZero && (state == M_FF || state == M_FF00));
    strb.statusWord = byteValid && (state == M_PRE);
    strb.pixelByte  = byteValid && !partOfCode;
  end

endmodule

// File: rtl/vsd_datapath.sv
module vsd_datapath
  import vsd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] word,
  input  ctrlStrobe_t       strb,
  output logic              savStrobe,
  output logic              eavStrobe,
  output logic              fieldOut,
  output logic              vblankOut,
  output logic              activeVideo,
  output logic              pixelValid,
  output logic [BYTE_W-1:0] pixelData,
  output logic              protErr
);

  localparam int PROT_W  = 4;
  localparam int FLAG_W  = 3;
  localparam int TOP_BIT = CODE_W - 1;
  localparam int F_BIT   = CODE_W - 2;
  localparam int V_BIT   = CODE_W - 3;
  localparam int H_BIT   = CODE_W - 4;
  // Which of {F,V,H} feed each protection bit, index = protection bit
  localparam logic [PROT_W-1:0][FLAG_W-1:0] PROT_MASK =
    {3'b011, 3'b101, 3'b110, 3'b111};

  logic [CODE_W-1:0] hdr;
  logic [FLAG_W-1:0] flags;
  logic [PROT_W-1:0] expProt;
  logic              codeOk;

  assign hdr   = word[BYTE_W-1 -: CODE_W];
  assign flags = {hdr[F_BIT], hdr[V_BIT], hdr[H_BIT]};

  for (genvar i = 0; i < PROT_W; i++) begin : g_prot
    assign expProt[i] = ^(flags & PROT_MASK[i]);
  end

  assign codeOk = hdr[TOP_BIT] && (hdr[PROT_W-1:0] == expProt);

  always_ff @(posedge clk) begin
    if (rst) begin
      savStrobe   <= 1'b0;
      eavStrobe   <= 1'b0;
      fieldOut    <= 1'b0;
      vblankOut   <= 1'b0;
      activeVideo <= 1'b0;
      pixelValid  <= 1'b0;
      pixelData   <= '0;
      protErr     <= 1'b0;
    end else begin
      savStrobe  <= 1'b0;
      eavStrobe  <= 1'b0;
      protErr    <= 1'b0;
      pixelValid <= strb.pixelByte && activeVideo;
      if (strb.pixelByte && activeVideo) pixelData <= word;
      if (strb.statusWord) begin
        if (codeOk) begin
          savStrobe   <= !hdr[H_BIT];
          eavStrobe   <= hdr[H_BIT];
          fieldOut    <= hdr[F_BIT];
          vblankOut   <= hdr[V_BIT];
          activeVideo <= !hdr[H_BIT] && !hdr[V_BIT];
        end else begin
          protErr <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/video_sync_decoder.sv
module video_sync_decoder
  import vsd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  output logic              savStrobe,
  output logic              eavStrobe,
  output logic              fieldOut,
  output logic              vblankOut,
  output logic              activeVideo,
  output logic              pixelValid,
  output logic [BYTE_W-1:0] pixelData,
  output logic              protErr
);

  ctrlStrobe_t strb;

  vsd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .byteValid (inValid),
    .codeByte  (inByte[BYTE_W-1 -: CODE_W]),
    .strb      (strb)
  );

  vsd_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .word        (inByte),
    .strb        (strb),
    .savStrobe   (savStrobe),
    .eavStrobe   (eavStrobe),
    .fieldOut    (fieldOut),
    .vblankOut   (vblankOut),
    .activeVideo (activeVideo),
    .pixelValid  (pixelValid),
    .pixelData   (pixelData),
    .protErr     (protErr)
  );

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [BYTE_W-1:0] inByte,
  input logic              savStrobe,
  input logic              eavStrobe,
  input logic              fieldOut,
  input logic              vblankOut,
  input logic              activeVideo,
  input logic              pixelValid,
  input logic [BYTE_W-1:0] pixelData,
  input logic              protErr
);

  p_status_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (savStrobe || eavStrobe || protErr) |-> $past(inValid));

  p_sav_eav_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(savStrobe && eavStrobe));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    (savStrobe || eavStrobe) |=> !(savStrobe || eavStrobe));

  p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
    protErr |-> ($stable(fieldOut) && $stable(vblankOut) && $stable(activeVideo)
                 && !savStrobe && !eavStrobe));

  p_err_single_r6: assert property (@(posedge clk) disable iff (rst)
    protErr |=> !protErr);

  p_active_vblank_r7: assert property (@(posedge clk) disable iff (rst)
    activeVideo |-> !vblankOut);

  p_eav_clears_r7: assert property (@(posedge clk) disable iff (rst)
    eavStrobe |-> !activeVideo);

  p_pixel_active_r8: assert property (@(posedge clk) disable iff (rst)
    pixelValid |-> ($past(activeVideo) && $past(inValid) && $past(inByte) == pixelData));

endmodule

bind video_sync_decoder vsd_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte),
  .savStrobe(savStrobe), .eavStrobe(eavStrobe), .fieldOut(fieldOut),
  .vblankOut(vblankOut), .activeVideo(activeVideo), .pixelValid(pixelValid),
  .pixelData(pixelData), .protErr(protErr)
);

// File: tb/sim_video_sync_decoder.sv
`timescale 1ns/1ps
module sim_video_sync_decoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic savStrobe, eavStrobe, fieldOut, vblankOut, activeVideo, pixelValid, protErr;
  logic [7:0] pixelData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  video_sync_decoder #(.BYTE_W(8)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte),
    .savStrobe(savStrobe), .eavStrobe(eavStrobe), .fieldOut(fieldOut),
    .vblankOut(vblankOut), .activeVideo(activeVideo), .pixelValid(pixelValid),
    .pixelData(pixelData), .protErr(protErr)
  );

  // Reference model: history of the last three valid bytes (h0 newest)
  logic [7:0] h0, h1, h2;
  bit c0, c1, c2;           // byte was consumed as a status byte
  bit mF, mV, mAct;
  logic [7:0] mPd;

  function automatic logic [7:0] mkStatus(bit f, bit v, bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic modelReset();
    h0 = 8'h00; h1 = 8'h00; h2 = 8'h00;
    c0 = 0; c1 = 0; c2 = 0;
    mF = 0; mV = 0; mAct = 0; mPd = 8'h00;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll(bit eSav, bit eEav, bit ePerr, bit ePix);
    chk("R4 savStrobe", {7'd0, savStrobe}, {7'd0, eSav});
    chk("R4 eavStrobe", {7'd0, eavStrobe}, {7'd0, eEav});
    chk("R5 fieldOut", {7'd0, fieldOut}, {7'd0, mF});
    chk("R5 vblankOut", {7'd0, vblankOut}, {7'd0, mV});
    chk("R6 protErr", {7'd0, protErr}, {7'd0, ePerr});
    chk("R7 activeVideo", {7'd0, activeVideo}, {7'd0, mAct});
    chk("R8 pixelValid", {7'd0, pixelValid}, {7'd0, ePix});
    if (ePix) chk("R8 pixelData", pixelData, mPd);
  endtask

  // Drive one byte, update the model, check outputs one edge later
  task automatic send(bit v, logic [7:0] b);
    bit isSt, isCode, ok, eSav, eEav, ePerr, ePix;
    eSav = 0; eEav = 0; ePerr = 0; ePix = 0;
    @(negedge clk);
    inValid = v; inByte = b;
    if (v) begin
      isSt   = (h2 == 8'hFF) && !c2 && (h1 == 8'h00) && (h0 == 8'h00);
      isCode = isSt || (b == 8'hFF) ||
               (b == 8'h00 && h0 == 8'hFF && !c0) ||
               (b == 8'h00 && h0 == 8'h00 && h1 == 8'hFF && !c1);
      ePix = !isCode && mAct;
      if (ePix) mPd = b;
      if (isSt) begin
        ok = b[7] && (b == mkStatus(b[6], b[5], b[4]));
        if (ok) begin
          eSav = !b[4]; eEav = b[4];
          mF = b[6]; mV = b[5];
          mAct = !b[4] && !b[5];
        end else ePerr = 1;
      end
      h2 = h1; c2 = c1; h1 = h0; c1 = c0; h0 = b; c0 = isSt;
    end
    @(posedge clk); #1;
    checkAll(eSav, eEav, ePerr, ePix);
  endtask

  task automatic sendCode(bit f, bit v, bit h, logic [7:0] flip);
    send(1, 8'hFF); send(1, 8'h00); send(1, 8'h00);
    send(1, mkStatus(f, v, h) ^ flip);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; inValid = 0;
    @(posedge clk); #1;
    modelReset();
    // R1: all outputs cleared by reset
    checkAll(0, 0, 0, 0);
    chk("R1 pixelData", pixelData, 8'h00);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    void'($urandom(32'h1f2e3d4c));
    modelReset();
    repeat (2) @(posedge clk);
    doReset();

    // Blanking line, then an active line in field 1 (R4, R5, R7, R8)
    send(1, 8'h80); send(1, 8'h10);
    sendCode(0, 1, 0, 8'h00);
    send(1, 8'h80);
    sendCode(0, 1, 1, 8'h00);
    sendCode(0, 0, 0, 8'h00);
    for (int i = 0; i < 6; i++) send(1, 8'h20 + 8'(i));
    sendCode(0, 0, 1, 8'h00);
    sendCode(1, 0, 0, 8'h00);
    send(1, 8'h55); send(0, 8'h66); send(1, 8'h77);

    // R6: corrupted protection bit and cleared top bit, state must hold
    sendCode(1, 1, 1, 8'h04);
    send(1, 8'h99);
    send(1, 8'hFF); send(1, 8'h00); send(1, 8'h00); send(1, 8'h00);
    send(1, 8'h42);

    // R2: broken preamble then would-be status gives no strobe
    send(1, 8'hFF); send(1, 8'h00); send(1, 8'h5A); send(1, mkStatus(0, 0, 1));
    // R2: invalid cycles inside the preamble do not break it
    send(1, 8'hFF); send(0, 8'h00); send(1, 8'h00); send(0, 8'h12);
    send(1, 8'h00); send(0, 8'hFF); send(1, mkStatus(1, 0, 1));

    // R3: 0xFF mid-preamble restarts the match at the first stage
    send(1, 8'hFF); send(1, 8'hFF); send(1, 8'h00); send(1, 8'h00);
    send(1, mkStatus(0, 0, 0));
    send(1, 8'h33);
    send(1, 8'hFF); send(1, 8'h00); send(1, 8'hFF); send(1, 8'h00); send(1, 8'h00);
    send(1, mkStatus(0, 0, 1));
    // R7: start code in blanking keeps active low
    sendCode(0, 1, 0, 8'h00);
    send(1, 8'h44);

    // Random lines mixed with codes, errors, gaps and reserved bytes
    for (int n = 0; n < 12000; n++) begin
      int r;
      r = int'($urandom % 16);
      rb = 8'($urandom);
      if (r < 3) begin
        logic [7:0] flip;
        flip = ($urandom % 6 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
        if (flip[6:4] != 3'b000) flip = 8'h80;
        sendCode(bit'($urandom), bit'($urandom % 4 == 0), bit'($urandom), flip);
      end
      else if (r == 3) send(0, rb);
      else if (r == 4) send(1, 8'hFF);
      else if (r == 5) send(1, 8'h00);
      else send(1, rb);
    end

    // R1: reset in the middle of an active line
    sendCode(0, 0, 0, 8'h00);
    send(1, 8'h61);
    send(1, 8'hFF);
    doReset();
    send(1, 8'h00); send(1, 8'h00); send(1, 8'h11);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule